// File: doc/BRIEF.md
# Interleaved Bitmap Display Address Generator

This block computes byte addresses into a 256 x 192 one-bit-per-pixel bitmap. The bitmap is stored in a non-linear order. Each display line is 32 bytes long. Consecutive 32-byte blocks in memory hold lines eight rows apart rather than adjacent lines. The screen is split into three bands of 64 lines, and each band repeats the same interleave on its own. The bitmap occupies 6144 bytes starting at a parameterised base address.

The block has two independent paths.

- **Translator.** A purely combinational path takes any pixel row and byte column and returns the address. It flags rows that lie below the visible area.
- **Scanner.** A registered path walks the visible area in raster order, one byte per enable pulse. Alongside each address it gives markers for the first byte of a line, the first byte of a frame, and the completion of a frame.

A video fetch engine uses the scanner. Software-side drawing logic uses the translator.

Top module: `vid_addr_gen`

## Requirements
- R1: For row r < 192 and column c, the translator address is BASE + r[7:6]*2048 + r[2:0]*256 + r[5:3]*32 + c.
- R2: Row 0 maps to offset 0, and rows 8, 16, 24 ... 56 map to offsets 32, 64, 96 ... 224, one 32-byte block apart.
- R3: Row 1 maps to offset 256, directly after the eighth block. Rows 64 and 128 start the second and third bands at offsets 2048 and 4096. Row 191, column 31 maps to offset 6143.
- R4: A translator row of 192 or above drives the out-of-range flag to 1 and the address to BASE (offset 0). Otherwise the flag is 0.
- R5: After reset, or after a synchronous clear, the scanner sits at row 0, column 0. Its address is BASE, the line-start and frame-start flags are 1, and frame-done is 0.
- R6: While enable is low and clear is low, the scanner's row, column and address do not change.
- R7: On each enabled cycle the column advances by one. From column 31 it returns to 0 and the row advances by one. Line-start is 1 exactly when the column is 0, and the row never reaches 192.
- R8: The enabled step out of row 191, column 31 wraps to row 0, column 0. In the following cycle, frame-done is 1 together with frame-start. Frame-done is 1 for that one cycle only.
- R9: Clear has priority over enable. It returns the scanner to row 0, column 0 on the next edge and suppresses frame-done, even when it coincides with the final step of a frame.
- R10: At every scanner position, the scanner address equals the R1 mapping of its current row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xl_row | input | 8 | Translator pixel row |
| xl_col | input | 5 | Translator byte column |
| xl_addr | output | ADDR_W | Translator byte address |
| xl_oor | output | 1 | Translator row is 192 or above |
| sc_clr | input | 1 | Scanner synchronous clear |
| sc_en | input | 1 | Scanner step enable |
| sc_addr | output | ADDR_W | Address of the current scanner byte |
| sc_row | output | 8 | Current scanner row |
| sc_col | output | 5 | Current scanner column |
| sc_line_start | output | 1 | Current byte is the first of a line |
| sc_frame_start | output | 1 | Current byte is the first of a frame |
| sc_frame_done | output | 1 | A frame finished on the previous edge |

## Verification
Frame completion and frame start fall in the same cycle. The bench steps the scanner through a whole frame with enable gaps inserted. It then checks, in the cycle after the last byte, that frame-done and frame-start are both 1 at address BASE, and that frame-done drops one cycle later. A second collision is provoked by raising clear together with enable while the scanner sits at row 191, column 31. There the bench checks that the scanner returns to the origin with frame-done held at 0.

// File: rtl/vag_pkg.sv
package vag_pkg;

  // Fixed screen geometry
  localparam int SCR_ROWS   = 192;
  localparam int SCR_COLS   = 32;
  localparam int ROW_W      = $clog2(256);
  localparam int COL_W      = $clog2(SCR_COLS);
  localparam int LINE_SEL_W = 3;   // pixel line inside an 8-line cell
  localparam int CELL_SEL_W = 3;   // cell row inside a band
  localparam int BAND_W     = ROW_W - LINE_SEL_W - CELL_SEL_W;
  localparam int OFF_W      = BAND_W + LINE_SEL_W + CELL_SEL_W + COL_W;
  localparam int BMP_BYTES  = SCR_ROWS * SCR_COLS;

  typedef logic [ROW_W-1:0] row_t;
  typedef logic [COL_W-1:0] col_t;
  typedef logic [OFF_W-1:0] off_t;

  typedef struct packed {
    logic line_start;
    logic frame_start;
    logic frame_done;
  } scan_flags_t;

endpackage

// File: rtl/vag_rst_sync.sv
module vag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/vag_xlate.sv
module vag_xlate
  import vag_pkg::*;
(
  input  row_t row,
  input  col_t col,
  output off_t offset,
  output logic oor
);

  localparam int LINE_LO = 0;
  localparam int CELL_LO = LINE_SEL_W;
  localparam int BAND_LO = LINE_SEL_W + CELL_SEL_W;

  logic [LINE_SEL_W-1:0] line_sel;
  logic [CELL_SEL_W-1:0] cell_sel;
  logic [BAND_W-1:0]     band_sel;
  off_t                  raw_off;

  always_comb begin
    line_sel = row[LINE_LO +: LINE_SEL_W];
    cell_sel = row[CELL_LO +: CELL_SEL_W];
    band_sel = row[BAND_LO +: BAND_W];
    raw_off  = {band_sel, line_sel, cell_sel, col};
    oor      = (row >= row_t'(SCR_ROWS));
    offset   = oor ? '0 : raw_off;
  end

endmodule

// File: rtl/vag_raster_cnt.sv
module vag_raster_cnt
  import vag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output row_t row,
  output col_t col,
  output logic wrap
);

  localparam row_t LAST_ROW = row_t'(SCR_ROWS - 1);
  localparam col_t LAST_COL = col_t'(SCR_COLS - 1);

  row_t row_q, row_d;
  col_t col_q, col_d;
  logic at_end;

  always_comb begin
    at_end = (row_q == LAST_ROW) && (col_q == LAST_COL);
    wrap   = en && !clr && at_end;
    row_d  = row_q;
    col_d  = col_q;
    if (clr) begin
      row_d = '0;
      col_d = '0;
    end else if (en) begin
      if (col_q == LAST_COL) begin
        col_d = '0;
        row_d = (row_q == LAST_ROW) ? '0 : row_q + row_t'(1);
      end else begin
        col_d = col_q + col_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row = row_q;
  assign col = col_q;

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(row_q) && $stable(col_q)));

  a_r7_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && col_q != LAST_COL) |=>
      (col_q == $past(col_q) + col_t'(1)) && (row_q == $past(row_q)));

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && col_q == LAST_COL && row_q != LAST_ROW) |=>
      (col_q == '0) && (row_q == $past(row_q) + row_t'(1)));

  a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q < row_t'(SCR_ROWS));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (row_q == '0) && (col_q == '0));

endmodule

// File: rtl/vag_frame_flags.sv
module vag_frame_flags
  import vag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wrap,
  input  row_t        row,
  input  col_t        col,
  output scan_flags_t flags
);

  logic done_q, done_d;

  always_comb begin
    done_d = wrap && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_comb begin
    flags.line_start  = (col == '0);
    flags.frame_start = (col == '0) && (row == '0);
    flags.frame_done  = done_q;
  end

  a_r8_done_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (row == '0) && (col == '0));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r9_clear_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done_q);

endmodule

// File: rtl/vid_addr_gen.sv
module vid_addr_gen
  import vag_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        xl_row,
  input  logic [4:0]        xl_col,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_oor,
  input  logic              sc_clr,
  input  logic              sc_en,
  output logic [ADDR_W-1:0] sc_addr,
  output logic [7:0]        sc_row,
  output logic [4:0]        sc_col,
  output logic              sc_line_start,
  output logic              sc_frame_start,
  output logic              sc_frame_done
);

  localparam int          NPATH  = 2;   // 0: translator, 1: scanner
  localparam int          PAD_W  = ADDR_W - OFF_W;
  localparam [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic        rst_ns;
  row_t        path_row [NPATH];
  col_t        path_col [NPATH];
  off_t        path_off [NPATH];
  logic        path_oor [NPATH];
  logic [ADDR_W-1:0] path_addr [NPATH];
  row_t        scan_row;
  col_t        scan_col;
  logic        scan_wrap;
  scan_flags_t scan_flags;

  vag_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  vag_raster_cnt u_cnt (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (sc_clr),
    .en    (sc_en),
    .row   (scan_row),
    .col   (scan_col),
    .wrap  (scan_wrap)
  );

  vag_frame_flags u_flags (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (sc_clr),
    .wrap  (scan_wrap),
    .row   (scan_row),
    .col   (scan_col),
    .flags (scan_flags)
  );

  always_comb begin
    path_row[0] = xl_row;
    path_col[0] = xl_col;
    path_row[1] = scan_row;
    path_col[1] = scan_col;
  end

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_path
    vag_xlate u_xl (
      .row    (path_row[gi]),
      .col    (path_col[gi]),
      .offset (path_off[gi]),
      .oor    (path_oor[gi])
    );
    assign path_addr[gi] = BASE_A + {{PAD_W{1'b0}}, path_off[gi]};
  end

  assign xl_addr        = path_addr[0];
  assign xl_oor         = path_oor[0];
  assign sc_addr        = path_addr[1];
  assign sc_row         = scan_row;
  assign sc_col         = scan_col;
  assign sc_line_start  = scan_flags.line_start;
  assign sc_frame_start = scan_flags.frame_start;
  assign sc_frame_done  = scan_flags.frame_done;

  a_r4_oor_base: assert property (@(posedge clk) disable iff (!rst_ns)
    xl_oor |-> (xl_addr == BASE_A));

  a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_ns)
    !xl_oor |-> ((xl_addr - BASE_A) < ADDR_W'(BMP_BYTES)));

  a_r10_scan_in_window: assert property (@(posedge clk) disable iff (!rst_ns)
    (sc_addr - BASE_A) < ADDR_W'(BMP_BYTES));

endmodule

// File: tb/tb_vid_addr_gen.sv
module tb_vid_addr_gen;

  localparam int ADDR_W = 16;
  localparam int BASE   = 16'h4000;
  localparam int NVEC   = 14;
  // row, col, expected offset, expected out-of-range
  localparam int VEC [NVEC][4] = '{
    '{0,   0,  0,    0}, '{8,   0,  32,   0}, '{16,  0,  64,   0},
    '{56,  31, 255,  0}, '{1,   0,  256,  0}, '{7,   0,  1792, 0},
    '{63,  31, 2047, 0}, '{64,  0,  2048, 0}, '{128, 0,  4096, 0},
    '{191, 31, 6143, 0}, '{9,   5,  293,  0}, '{100, 10, 3210, 0},
    '{192, 0,  0,    1}, '{255, 31, 0,    1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] xl_row;
  logic [4:0] xl_col;
  logic [ADDR_W-1:0] xl_addr, sc_addr;
  logic xl_oor, sc_clr, sc_en;
  logic [7:0] sc_row;
  logic [4:0] sc_col;
  logic sc_line_start, sc_frame_start, sc_frame_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vid_addr_gen #(.ADDR_W(ADDR_W), .BASE(16'h4000)) dut (
    .clk(clk), .rst_n(rst_n),
    .xl_row(xl_row), .xl_col(xl_col), .xl_addr(xl_addr), .xl_oor(xl_oor),
    .sc_clr(sc_clr), .sc_en(sc_en), .sc_addr(sc_addr),
    .sc_row(sc_row), .sc_col(sc_col),
    .sc_line_start(sc_line_start), .sc_frame_start(sc_frame_start),
    .sc_frame_done(sc_frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_off(input int r, input int c);
    return (r / 64) * 2048 + (r % 8) * 256 + ((r / 8) % 8) * 32 + c;
  endfunction

  // Checks all scanner outputs against the model position
  task automatic chk_scan(input int er, input int ec, input bit edone, input string req);
    chk(sc_row == 8'(er), req, int'(sc_row), er);
    chk(sc_col == 5'(ec), req, int'(sc_col), ec);
    chk(sc_addr == ADDR_W'(BASE + model_off(er, ec)), {req, "/R10 addr"},
        int'(sc_addr), BASE + model_off(er, ec));
    chk(sc_line_start == (ec == 0), {req, "/R7 line_start"}, int'(sc_line_start), int'(ec == 0));
    chk(sc_frame_start == (er == 0 && ec == 0), {req, " frame_start"},
        int'(sc_frame_start), int'(er == 0 && ec == 0));
    chk(sc_frame_done == edone, {req, "/R8 frame_done"}, int'(sc_frame_done), int'(edone));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int er, ec;
    bit edone;
    rst_n  = 1'b0;
    sc_clr = 1'b0;
    sc_en  = 1'b0;
    xl_row = '0;
    xl_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: reset state
    chk_scan(0, 0, 1'b0, "R5 reset");

    // R1..R4: translator table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      xl_row = 8'(VEC[i][0]);
      xl_col = 5'(VEC[i][1]);
      #2;
      chk(xl_addr == ADDR_W'(BASE + VEC[i][2]), "R1/R2/R3/R4 xl_addr",
          int'(xl_addr), BASE + VEC[i][2]);
      chk(xl_oor == VEC[i][3][0], "R4 xl_oor", int'(xl_oor), VEC[i][3]);
    end

    // R1: translator sweep against the arithmetic model
    for (int r = 0; r < 192; r += 5) begin
      @(negedge clk);
      xl_row = 8'(r);
      xl_col = 5'((r * 7) % 32);
      #2;
      chk(xl_addr == ADDR_W'(BASE + model_off(r, (r * 7) % 32)), "R1 sweep",
          int'(xl_addr), BASE + model_off(r, (r * 7) % 32));
    end

    // R6: hold while enable low
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk_scan(0, 0, 1'b0, "R6 hold");

    // R7/R8/R10: full frame with gaps, then check the wrap cycle
    er = 0; ec = 0; edone = 1'b0;
    for (int i = 0; i < 6144 * 3 / 2 + 2; i++) begin
      @(negedge clk);
      chk_scan(er, ec, edone, "R7 raster");
      if (i > 0 && edone) break;
      sc_en = (i % 3 != 2);
      edone = 1'b0;
      if (sc_en) begin
        if (ec == 31) begin
          ec = 0;
          if (er == 191) begin er = 0; edone = 1'b1; end
          else er = er + 1;
        end else ec = ec + 1;
      end
    end
    chk(edone == 1'b1, "R8 frame completed", int'(edone), 1);
    // frame_done lasts one cycle
    sc_en = 1'b0;
    @(negedge clk);
    chk_scan(0, 0, 1'b0, "R8 single pulse");

    // R9: clear mid-line with enable high
    sc_en = 1'b1;
    repeat (40) @(negedge clk);
    chk_scan(1, 8, 1'b0, "R7 advance");
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    sc_en  = 1'b0;
    chk_scan(0, 0, 1'b0, "R9 clear");

    // R9: clear coinciding with final step suppresses frame_done
    sc_en = 1'b1;
    repeat (6143) @(negedge clk);
    sc_en = 1'b0;
    chk_scan(191, 31, 1'b0, "R9 at last byte");
    sc_en  = 1'b1;
    sc_clr = 1'b1;
    @(negedge clk);
    sc_en  = 1'b0;
    sc_clr = 1'b0;
    chk_scan(0, 0, 1'b0, "R9 clear beats wrap");
    @(negedge clk);
    chk_scan(0, 0, 1'b0, "R9 no late done");

    // R5: asynchronous reset mid-frame
    sc_en = 1'b1;
    repeat (10) @(negedge clk);
    sc_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_scan(0, 0, 1'b0, "R5 re-reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule